// File: doc/BRIEF.md
# Coupling-Aware Multi-Pattern Flit Inversion Codec

This block sits at the network-interface edge of an on-chip link. It reduces the energy spent on crosstalk between neighbouring wires. Each outgoing body flit carries a payload of `LINK_W-2` bits. The transmit side tries four ways of sending it:

- unchanged;
- with the odd-indexed bits inverted;
- with the even-indexed bits inverted;
- with every bit inverted.

The transmit side scores each candidate against the flit that went out on the wire just before it. It then sends the cheapest candidate together with a 2-bit action code in the top two wire bits.

The scoring works one adjacent payload pair at a time. A pair where exactly one wire toggles costs 1. A pair where both wires toggle in opposite directions costs 2. A pair where neither wire toggles, or both toggle the same way, costs nothing.

Per-pair classifiers flag the costly pairs for each candidate. Ones counters total the flags, and a picker takes the lowest total. The receive side reads the action code and undoes the matching inversion. Receive and transmit are independent streams. In the testbench they are looped back to form a complete link.

Both streams use valid/ready. A flit moves when valid and ready are both high at a rising clock edge. The transmit side has a single output register:
- It accepts a new flit when that register is empty or is being drained in the same cycle.
- While its output is stalled, it holds the output data unchanged.

The receive side is combinational. Its ready follows the downstream ready, and its valid follows the upstream valid.

Top module: `cpl_link_codec`

## Requirements
- R1: After reset, `tx_out_valid` is 0, `tx_in_ready` is 1, and the reference flit used for the first comparison is all zeros.
- R2: A transmitted flit carries the action code in bits [LINK_W-1:LINK_W-2] and the payload XOR the action's mask in bits [LINK_W-3:0]. The codes are 00 for none (mask 0), 10 for odd (payload bit indices 1,3,5,… set), 01 for even (indices 0,2,4,… set) and 11 for full (all bits set).
- R3: The chosen action's cost is never above the cost of any other action. Cost is measured against the previous transmitted payload, summed over payload pairs (i,i+1) only: 1 when one bit toggles, 2 when both toggle in opposite directions, 0 otherwise.
- R4: When costs are equal, the lowest-cost action is chosen by the priority none, then odd, then even, then full.
- R5: The reference is the payload bits of the last transmitted flit. It changes only when an input handshake is accepted, so input data presented without an accepted handshake has no effect.
- R6: A flit accepted at a clock edge appears on `tx_out_data` with `tx_out_valid` high right after that same edge.
- R7: While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_data` stays stable, `tx_out_valid` stays high and `tx_in_ready` is low.
- R8: `rx_out_data` equals `rx_in_data[LINK_W-3:0]` XOR the mask selected by `rx_in_data[LINK_W-1:LINK_W-2]`. Also, `rx_out_valid` equals `rx_in_valid` and `rx_in_ready` equals `rx_out_ready`. A loopback returns every payload unchanged and in order.
- R9: A payload equal to the reference payload is sent with code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Payload offered for encoding |
| tx_in_ready | output | 1 | Encoder can take a payload |
| tx_in_data | input | LINK_W-2 | Payload to encode |
| tx_out_valid | output | 1 | Encoded flit on the link |
| tx_out_ready | input | 1 | Link accepts the flit |
| tx_out_data | output | LINK_W | Action code and encoded payload |
| rx_in_valid | input | 1 | Encoded flit arriving |
| rx_in_ready | output | 1 | Decoder can take the flit |
| rx_in_data | input | LINK_W | Received encoded flit |
| rx_out_valid | output | 1 | Decoded payload valid |
| rx_out_ready | input | 1 | Consumer accepts payload |
| rx_out_data | output | LINK_W-2 | Restored payload |

## Verification
The hardest case to reach is a tie between two non-trivial actions, because only a reference with a particular structure makes two inversions score the same. The stimulus builds such references on purpose. It first sends uniform payloads, then alternating ones, so that the odd and even inversions both fall to zero cost and the priority order decides. Random and correlated (few-bit-flip) streams follow under a randomly stalling sink. This exercises full inversion and back-pressure, with input data changed while no handshake happens.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_EVEN = 2'b01,
    ACT_ODD  = 2'b10,
    ACT_FULL = 2'b11
  } act_e;
  localparam int NUM_CAND = 4;
endpackage

// File: rtl/cpl_mask_gen.sv
module cpl_mask_gen #(
  parameter int PW = 14
) (
  input  logic [1:0]    code,
  output logic [PW-1:0] mask
);
  import cpl_pkg::*;
  for (genvar i = 0; i < PW; i++) begin : g_bit
    if (i % 2 == 1) begin : g_odd
      assign mask[i] = (code == ACT_ODD) || (code == ACT_FULL);
    end else begin : g_even
      assign mask[i] = (code == ACT_EVEN) || (code == ACT_FULL);
    end
  end
endmodule

// File: rtl/cpl_pair_class.sv
module cpl_pair_class (
  input  logic [1:0] prev_pair,
  input  logic [1:0] cur_pair,
  output logic       single_sw,
  output logic       opposed_sw
);
  logic [1:0] tog;
  assign tog        = prev_pair ^ cur_pair;
  assign single_sw  = tog[0] ^ tog[1];
  assign opposed_sw = tog[0] & tog[1] & (prev_pair[0] ^ prev_pair[1]);
endmodule

// File: rtl/cpl_ones_count.sv
module cpl_ones_count #(
  parameter int N = 13,
  localparam int CNTW = $clog2(N + 1)
) (
  input  logic [N-1:0]    bits,
  output logic [CNTW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CNTW'(bits[i]);
  end
endmodule

// File: rtl/cpl_action_pick.sv
module cpl_action_pick #(
  parameter int CW = 5
) (
  input  logic [cpl_pkg::NUM_CAND-1:0][CW-1:0] cost,
  output logic [1:0]                           sel
);
  logic [CW-1:0] best;
  always_comb begin
    sel  = 2'd0;
    best = cost[0];
    for (int i = 1; i < cpl_pkg::NUM_CAND; i++) begin
      if (cost[i] < best) begin
        best = cost[i];
        sel  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/cpl_tx_encoder.sv
module cpl_tx_encoder #(
  parameter int LINK_W = 16,
  localparam int PW   = LINK_W - 2,
  localparam int NP   = PW - 1,
  localparam int NW   = $clog2(NP + 1),
  localparam int CW   = $clog2(2 * NP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINK_W-1:0] out_data
);
  import cpl_pkg::*;

  // candidate order doubles as tie priority
  localparam logic [NUM_CAND-1:0][1:0] CAND_CODE = {ACT_FULL, ACT_EVEN, ACT_ODD, ACT_NONE};

  logic [LINK_W-1:0]             link_q;
  logic                          valid_q;
  logic [PW-1:0]                 ref_pay;
  logic [NUM_CAND-1:0][PW-1:0]   msk;
  logic [NUM_CAND-1:0][PW-1:0]   cand;
  logic [NUM_CAND-1:0][NP-1:0]   one_flag;
  logic [NUM_CAND-1:0][NP-1:0]   two_flag;
  logic [NUM_CAND-1:0][NW-1:0]   one_cnt;
  logic [NUM_CAND-1:0][NW-1:0]   two_cnt;
  logic [NUM_CAND-1:0][CW-1:0]   cost;
  logic [1:0]                    sel;
  logic                          accept;

  assign ref_pay = link_q[PW-1:0];

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    cpl_mask_gen #(.PW(PW)) u_mask (.code(CAND_CODE[c]), .mask(msk[c]));
    assign cand[c] = in_data ^ msk[c];
    for (genvar j = 0; j < NP; j++) begin : g_pair
      cpl_pair_class u_cls (
        .prev_pair (ref_pay[j+1:j]),
        .cur_pair  (cand[c][j+1:j]),
        .single_sw (one_flag[c][j]),
        .opposed_sw(two_flag[c][j])
      );
    end
    cpl_ones_count #(.N(NP)) u_cnt1 (.bits(one_flag[c]), .count(one_cnt[c]));
    cpl_ones_count #(.N(NP)) u_cnt2 (.bits(two_flag[c]), .count(two_cnt[c]));
    assign cost[c] = CW'(one_cnt[c]) + CW'({two_cnt[c], 1'b0});
  end

  cpl_action_pick #(.CW(CW)) u_pick (.cost(cost), .sel(sel));

  assign in_ready  = !valid_q || out_ready;
  assign accept    = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_data  = link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q  <= '0;
      valid_q <= 1'b0;
    end else if (accept) begin
      link_q  <= {CAND_CODE[sel], cand[sel]};
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpl_rx_decoder.sv
module cpl_rx_decoder #(
  parameter int LINK_W = 16,
  localparam int PW = LINK_W - 2
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINK_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PW-1:0]     out_data
);
  logic [PW-1:0] msk;
  cpl_mask_gen #(.PW(PW)) u_mask (.code(in_data[LINK_W-1:LINK_W-2]), .mask(msk));
  assign out_data  = in_data[PW-1:0] ^ msk;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/cpl_link_codec.sv
module cpl_link_codec #(
  parameter int LINK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [LINK_W-3:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [LINK_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [LINK_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [LINK_W-3:0] rx_out_data
);
  cpl_tx_encoder #(.LINK_W(LINK_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_in_valid),
    .in_ready (tx_in_ready),
    .in_data  (tx_in_data),
    .out_valid(tx_out_valid),
    .out_ready(tx_out_ready),
    .out_data (tx_out_data)
  );

  cpl_rx_decoder #(.LINK_W(LINK_W)) u_dec (
    .in_valid (rx_in_valid),
    .in_ready (rx_in_ready),
    .in_data  (rx_in_data),
    .out_valid(rx_out_valid),
    .out_ready(rx_out_ready),
    .out_data (rx_out_data)
  );
endmodule

// File: rtl/cpl_link_codec_chk.sv
module cpl_link_codec_chk #(
  parameter int LINK_W = 16,
  localparam int PW = LINK_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic [PW-1:0]     tx_in_data,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [LINK_W-1:0] tx_out_data,
  input logic [LINK_W-1:0] rx_in_data,
  input logic [PW-1:0]     rx_out_data
);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |-> !tx_in_ready);

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_in_valid && tx_in_ready) |=> $stable(tx_out_data));

  // R9
  repeat_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready && (tx_in_data == tx_out_data[PW-1:0])
    |=> tx_out_data[LINK_W-1:LINK_W-2] == 2'b00);

  // R8
  dec_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_data[LINK_W-1:LINK_W-2] == 2'b00 |-> rx_out_data == rx_in_data[PW-1:0]);

  // R8
  dec_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_data[LINK_W-1:LINK_W-2] == 2'b11 |-> rx_out_data == ~rx_in_data[PW-1:0]);
endmodule

bind cpl_link_codec cpl_link_codec_chk #(.LINK_W(LINK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_in_valid (tx_in_valid),
  .tx_in_ready (tx_in_ready),
  .tx_in_data  (tx_in_data),
  .tx_out_valid(tx_out_valid),
  .tx_out_ready(tx_out_ready),
  .tx_out_data (tx_out_data),
  .rx_in_data  (rx_in_data),
  .rx_out_data (rx_out_data)
);

// File: tb/cpl_link_codec_bench.sv
module cpl_link_codec_bench;
  localparam int W = 16;
  localparam int P = W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 1'b0;
  logic [P-1:0] tx_in_data = '0;
  logic tx_in_ready, tx_out_valid, tx_out_ready, rx_in_valid, rx_in_ready, rx_out_valid;
  logic [W-1:0] tx_out_data, rx_in_data;
  logic [P-1:0] rx_out_data;
  logic sink_ready = 1'b0;
  int   ready_pct = 75;

  always #5 clk = ~clk;

  cpl_link_codec #(.LINK_W(W)) u_cpl_link_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(sink_ready), .rx_out_data(rx_out_data)
  );

  assign rx_in_valid  = tx_out_valid;
  assign rx_in_data   = tx_out_data;
  assign tx_out_ready = rx_in_ready;

  int checks = 0;
  int fails  = 0;
  int act_seen [4];

  typedef struct { logic [P-1:0] pay; } item_t;
  item_t sb[$];
  logic [P-1:0] model_ref = '0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [P-1:0] mask_of(input logic [1:0] code);
    logic [P-1:0] m;
    for (int i = 0; i < P; i++)
      m[i] = (code == 2'b11) || (code == 2'b10 && i % 2 == 1) || (code == 2'b01 && i % 2 == 0);
    return m;
  endfunction

  function automatic int wire_cost(input logic [P-1:0] pv, input logic [P-1:0] cv);
    int c = 0;
    for (int j = 0; j < P - 1; j++) begin
      logic t0, t1;
      t0 = pv[j] ^ cv[j];
      t1 = pv[j+1] ^ cv[j+1];
      if (t0 != t1) c += 1;
      else if (t0 && t1 && (pv[j] != pv[j+1])) c += 2;
    end
    return c;
  endfunction

  // priority order none, odd, even, full
  function automatic logic [1:0] best_code(input logic [P-1:0] pv, input logic [P-1:0] p);
    logic [1:0] order [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
    logic [1:0] b = 2'b00;
    int bc = wire_cost(pv, p);
    for (int k = 1; k < 4; k++) begin
      int c = wire_cost(pv, p ^ mask_of(order[k]));
      if (c < bc) begin bc = c; b = order[k]; end
    end
    return b;
  endfunction

  task automatic send(input logic [P-1:0] p, input int hand_code);
    logic [1:0]   code;
    logic [W-1:0] exp;
    logic [P-1:0] ref_before;
    int dut_cost;
    ref_before = model_ref;
    code = best_code(model_ref, p);
    exp  = {code, p ^ mask_of(code)};
    sb.push_back('{pay: p});
    model_ref = exp[P-1:0];
    tx_in_valid = 1'b1;
    tx_in_data  = p;
    while (!tx_in_ready) @(negedge clk);
    @(negedge clk);
    chk(tx_out_valid == 1'b1, "R6 output valid after accept", W'(tx_out_valid), W'(1));
    chk(tx_out_data == exp, "R2 encoded flit", tx_out_data, exp);
    dut_cost = wire_cost(ref_before, tx_out_data[P-1:0]);
    for (int k = 0; k < 4; k++) begin
      int oc = wire_cost(ref_before, p ^ mask_of(2'(k)));
      if (dut_cost > oc) chk(1'b0, "R3 chosen cost above alternative", W'(dut_cost), W'(oc));
    end
    checks++;
    act_seen[tx_out_data[W-1:W-2]]++;
    if (hand_code >= 0)
      chk(tx_out_data[W-1:W-2] == 2'(hand_code), "R4/R9 hand code", W'(tx_out_data[W-1:W-2]), W'(hand_code));
  endtask

  // sink back-pressure, changed away from edges
  always @(posedge clk) #2 sink_ready = ($urandom % 100) < ready_pct;

  // scoreboard monitor and stall checks
  logic         last_stall = 1'b0;
  logic [W-1:0] last_data  = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (last_stall)
        chk(tx_out_valid && tx_out_data == last_data, "R7 stalled output held", tx_out_data, last_data);
      if (rx_out_valid && sink_ready) begin
        if (sb.size() == 0) chk(1'b0, "R8 unexpected output", W'(rx_out_data), '0);
        else begin
          item_t it;
          it = sb.pop_front();
          chk(rx_out_data == it.pay, "R8 round trip", W'(rx_out_data), W'(it.pay));
        end
      end
      last_stall = tx_out_valid && !sink_ready;
      last_data  = tx_out_data;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [P-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_out_valid == 1'b0, "R1 valid low after reset", W'(tx_out_valid), '0);
    chk(tx_in_ready == 1'b1, "R1 ready high after reset", W'(tx_in_ready), W'(1));
    // R1/R9: zero against zero reference
    send('0, 0);
    send('1, 0);                      // R4 none vs full tie
    send('0, 0);                      // R4 all fall together
    send(P'(14'h1555), 2);            // R4 odd vs even tie -> odd (10)
    send(P'(14'h2AAA), 2);            // R4 tie again -> odd
    send(P'(14'h2AAA), -1);
    // R5: junk without handshake
    tx_in_valid = 1'b0;
    tx_in_data  = P'($urandom);
    repeat (4) @(negedge clk);
    tx_in_data  = P'($urandom);
    @(negedge clk);
    send(model_ref, 0);               // R9 repeat of reference -> none
    ready_pct = 40;
    for (int n = 0; n < 200; n++) send(P'($urandom), -1);
    v = model_ref;
    for (int n = 0; n < 200; n++) begin
      v = v ^ (P'(1) << ($urandom % P)) ^ ((($urandom % 3) == 0) ? (P'(1) << ($urandom % P)) : '0);
      send(v, -1);
      if (n % 37 == 0) begin tx_in_valid = 1'b0; repeat (3) @(negedge clk); end
    end
    ready_pct = 100;
    tx_in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    chk(act_seen[3] > 0 && act_seen[1] > 0, "R2 full and even codes used", W'(act_seen[3]), W'(1));
    finish_run();
  end
endmodule